// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This control block turns one floating-point data-processing instruction into a series of element operations. The register file holds 32 single-precision or 16 double-precision entries. On a start pulse the block takes a snapshot of the destination index and the two source indices, the precision, the operation class, and the vector length and stride fields of the control register. After that it issues one set of register indices per cycle. Each set comes with a valid flag, a last flag and a write-back-only flag. The downstream arithmetic pipe can hold the sequence with a stall input.

The destination's bank decides the mode. A destination in bank 0 gives a scalar operation, whatever the vector length. Any other bank gives a vector operation, and its element count is the vector length plus one. A second-source register in bank 0 stays fixed across a vector operation (mixed scalar/vector mode). A single-source operation with such a source is computed once, and its result is then written to the remaining destination indices (broadcast mode). An index always stays inside its own bank and wraps at the bank edge.

Top module: `fpv_seq_top`

## Requirements
- R1: After synchronous reset, `el_valid_o`, `el_last_o`, `el_wb_only_o` and `busy_o` are all 0.
- R2: A `start_i` pulse while `busy_o` is 0 makes the next cycle show element 0, with `el_rd_o`/`el_rn_o`/`el_rm_o` equal to the sampled `rd_i`/`rn_i`/`rm_i` and `el_valid_o` = `busy_o` = 1.
- R3: A destination in bank 0 gives exactly one element (last = 1) for any vector length. The bank is index bits [4:3] for single precision (`dbl_i`=0) and bits [3:2] for double precision (`dbl_i`=1).
- R4: A vector operation issues `vlen_i`+1 elements, and only the final one has `el_last_o` = 1. `busy_o` equals `el_valid_o`, and both fall in the cycle after the last element is accepted.
- R5: Between elements, the destination moves by `vstride_i`+1 in single precision and by (`vstride_i`>>1)+1 in double precision. The low 3 bits (single) or low 2 bits (double) wrap modulo the bank size, and all higher bits stay unchanged.
- R6: In a vector operation, `el_rm_o` stays fixed when `rm_i` lies in bank 0. Otherwise it moves and wraps exactly as the destination does.
- R7: `op_cls_i` encoding: 0 = two-source arithmetic, 1 = single-source operation, 2 or 3 = compare/convert. For class 0, `el_rn_o` moves with the destination each element. For every other class it stays fixed.
- R8: Classes 2 and 3 always give one element, whatever the vector length and the banks.
- R9: Class 1 with a vector destination and a bank-0 source marks element 0 with `el_wb_only_o` = 0 and every later element with `el_wb_only_o` = 1. `el_rm_o` stays fixed and the destination keeps stepping.
- R10: While `el_valid_o` and `stall_i` are both 1, every element output holds its value at the next edge.
- R11: `start_i` while `busy_o` is 1 is ignored. The running sequence completes unchanged and no new sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a sequence when idle |
| dbl_i | input | 1 | 1 = double precision, 0 = single |
| op_cls_i | input | 2 | Operation class (see R7) |
| rd_i | input | 5 | Destination index |
| rn_i | input | 5 | First source index |
| rm_i | input | 5 | Second / only source index |
| vlen_i | input | 3 | Vector length field (elements minus one) |
| vstride_i | input | 2 | Vector stride field |
| stall_i | input | 1 | Hold the current element |
| busy_o | output | 1 | Sequence in progress |
| el_valid_o | output | 1 | Element indices valid |
| el_last_o | output | 1 | Final element of the sequence |
| el_wb_only_o | output | 1 | Write back previous result, no compute |
| el_rd_o | output | 5 | Element destination index |
| el_rn_o | output | 5 | Element first source index |
| el_rm_o | output | 5 | Element second source index |

## Verification
The stimulus covers scalar destinations with non-zero lengths, full vectors in both precisions at every stride, and mixed operations with a bank-0 second source. Broadcast runs and compare/convert runs with vector-bank operands are also applied. The destinations are chosen near bank ends, so a wrap that leaks a carry into the bank bits gives a wrong index. Double-precision runs at strides 1 and 3 separate the halved step from the single-precision step. Stall patterns in the middle of a sequence and start pulses held high during a busy run show whether the hold logic and the idle gating keep the element order.

// File: rtl/fpv_seq_pkg.sv
package fpv_seq_pkg;
  typedef enum logic [1:0] {
    CLS_DUAL      = 2'd0,
    CLS_MONO      = 2'd1,
    CLS_FIXED     = 2'd2,
    CLS_FIXED_ALT = 2'd3
  } op_cls_e;

  typedef struct packed {
    logic vec;
    logic bcast;
    logic rn_adv;
    logic rm_adv;
  } seq_mode_t;

  localparam int NUM_LANES = 3;
  localparam int LANE_RD   = 0;
  localparam int LANE_RN   = 1;
  localparam int LANE_RM   = 2;
endpackage

// File: rtl/fpv_seq_plan.sv
module fpv_seq_plan
  import fpv_seq_pkg::*;
#(
  parameter int LEN_W    = 3,
  parameter int STRIDE_W = 2,
  parameter int BANK_W   = 2,
  parameter int STEP_W   = STRIDE_W + 1
) (
  input  op_cls_e            cls,
  input  logic               dbl,
  input  logic [BANK_W-1:0]  rd_bank_s,
  input  logic [BANK_W-1:0]  rd_bank_d,
  input  logic [BANK_W-1:0]  rm_bank_s,
  input  logic [BANK_W-1:0]  rm_bank_d,
  input  logic [LEN_W-1:0]   vlen,
  input  logic [STRIDE_W-1:0] stride,
  output seq_mode_t          mode,
  output logic [STEP_W-1:0]  step,
  output logic [LEN_W-1:0]   count
);
  logic [BANK_W-1:0] rd_bank;
  logic [BANK_W-1:0] rm_bank;
  logic              vec_cls;
  logic              is_vec;

  assign rd_bank = dbl ? rd_bank_d : rd_bank_s;
  assign rm_bank = dbl ? rm_bank_d : rm_bank_s;
  assign vec_cls = (cls == CLS_DUAL) || (cls == CLS_MONO);
  assign is_vec  = vec_cls && (vlen != '0) && (rd_bank != '0);

  always_comb begin
    if (dbl) step = STEP_W'(stride >> 1) + STEP_W'(1);
    else     step = STEP_W'(stride) + STEP_W'(1);
  end

  always_comb begin
    mode.vec    = is_vec;
    mode.rn_adv = is_vec && (cls == CLS_DUAL);
    mode.rm_adv = is_vec && (rm_bank != '0);
    mode.bcast  = is_vec && (cls == CLS_MONO) && (rm_bank == '0);
    count       = is_vec ? vlen : '0;
  end
endmodule

// File: rtl/fpv_seq_wrap.sv
module fpv_seq_wrap #(
  parameter int IDX_W   = 5,
  parameter int STEP_W  = 3,
  parameter int SGL_LOW = 3,
  parameter int DBL_LOW = 2
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [STEP_W-1:0] step,
  input  logic              dbl,
  output logic [IDX_W-1:0]  nxt
);
  logic [SGL_LOW-1:0] s_low;
  logic [DBL_LOW-1:0] d_low;

  assign s_low = idx[SGL_LOW-1:0] + SGL_LOW'(step);
  assign d_low = idx[DBL_LOW-1:0] + DBL_LOW'(step);

  assign nxt = dbl ? {idx[IDX_W-1:DBL_LOW], d_low}
                   : {idx[IDX_W-1:SGL_LOW], s_low};
endmodule

// File: rtl/fpv_seq_top.sv
module fpv_seq_top
  import fpv_seq_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int LEN_W    = 3,
  parameter int STRIDE_W = 2,
  parameter int SGL_LOW  = 3,
  parameter int DBL_LOW  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                dbl_i,
  input  logic [1:0]          op_cls_i,
  input  logic [IDX_W-1:0]    rd_i,
  input  logic [IDX_W-1:0]    rn_i,
  input  logic [IDX_W-1:0]    rm_i,
  input  logic [LEN_W-1:0]    vlen_i,
  input  logic [STRIDE_W-1:0] vstride_i,
  input  logic                stall_i,
  output logic                busy_o,
  output logic                el_valid_o,
  output logic                el_last_o,
  output logic                el_wb_only_o,
  output logic [IDX_W-1:0]    el_rd_o,
  output logic [IDX_W-1:0]    el_rn_o,
  output logic [IDX_W-1:0]    el_rm_o
);
  localparam int BANK_W = 2;
  localparam int STEP_W = STRIDE_W + 1;

  seq_mode_t         pl_mode;
  logic [STEP_W-1:0] pl_step;
  logic [LEN_W-1:0]  pl_count;

  fpv_seq_plan #(
    .LEN_W(LEN_W), .STRIDE_W(STRIDE_W), .BANK_W(BANK_W), .STEP_W(STEP_W)
  ) u_plan (
    .cls       (op_cls_e'(op_cls_i)),
    .dbl       (dbl_i),
    .rd_bank_s (rd_i[SGL_LOW +: BANK_W]),
    .rd_bank_d (rd_i[DBL_LOW +: BANK_W]),
    .rm_bank_s (rm_i[SGL_LOW +: BANK_W]),
    .rm_bank_d (rm_i[DBL_LOW +: BANK_W]),
    .vlen      (vlen_i),
    .stride    (vstride_i),
    .mode      (pl_mode),
    .step      (pl_step),
    .count     (pl_count)
  );

  logic              valid_q, busy_q, last_q, wb_q, dbl_q, bcast_q;
  logic [STEP_W-1:0] step_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q   [NUM_LANES];
  logic [IDX_W-1:0]  idx_nx  [NUM_LANES];
  logic [IDX_W-1:0]  idx_in  [NUM_LANES];
  logic              adv_q   [NUM_LANES];
  logic              adv_in  [NUM_LANES];

  assign idx_in[LANE_RD] = rd_i;
  assign idx_in[LANE_RN] = rn_i;
  assign idx_in[LANE_RM] = rm_i;
  assign adv_in[LANE_RD] = pl_mode.vec;
  assign adv_in[LANE_RN] = pl_mode.rn_adv;
  assign adv_in[LANE_RM] = pl_mode.rm_adv;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [IDX_W-1:0] wrapped;

    fpv_seq_wrap #(
      .IDX_W(IDX_W), .STEP_W(STEP_W), .SGL_LOW(SGL_LOW), .DBL_LOW(DBL_LOW)
    ) u_wrap (
      .idx  (idx_q[g]),
      .step (step_q),
      .dbl  (dbl_q),
      .nxt  (wrapped)
    );

    assign idx_nx[g] = adv_q[g] ? wrapped : idx_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        idx_q[g] <= '0;
        adv_q[g] <= 1'b0;
      end else if (!busy_q) begin
        if (start_i) begin
          idx_q[g] <= idx_in[g];
          adv_q[g] <= adv_in[g];
        end
      end else if (!stall_i && !last_q) begin
        idx_q[g] <= idx_nx[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
      wb_q    <= 1'b0;
      dbl_q   <= 1'b0;
      bcast_q <= 1'b0;
      step_q  <= '0;
      cnt_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        valid_q <= 1'b1;
        busy_q  <= 1'b1;
        last_q  <= (pl_count == '0);
        wb_q    <= 1'b0;
        dbl_q   <= dbl_i;
        bcast_q <= pl_mode.bcast;
        step_q  <= pl_step;
        cnt_q   <= pl_count;
      end
    end else if (!stall_i) begin
      if (last_q) begin
        valid_q <= 1'b0;
        busy_q  <= 1'b0;
        last_q  <= 1'b0;
        wb_q    <= 1'b0;
      end else begin
        cnt_q  <= cnt_q - LEN_W'(1);
        last_q <= (cnt_q == LEN_W'(1));
        wb_q   <= bcast_q;
      end
    end
  end

  assign busy_o       = busy_q;
  assign el_valid_o   = valid_q;
  assign el_last_o    = last_q;
  assign el_wb_only_o = wb_q;
  assign el_rd_o      = idx_q[LANE_RD];
  assign el_rn_o      = idx_q[LANE_RN];
  assign el_rm_o      = idx_q[LANE_RM];
endmodule

// File: rtl/fpv_seq_checker.sv
module fpv_seq_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             stall_i,
  input logic [IDX_W-1:0] rd_i,
  input logic             busy_o,
  input logic             el_valid_o,
  input logic             el_last_o,
  input logic             el_wb_only_o,
  input logic [IDX_W-1:0] el_rd_o,
  input logic [IDX_W-1:0] el_rn_o,
  input logic [IDX_W-1:0] el_rm_o
);
  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (el_valid_o && el_rd_o == $past(rd_i)));

  a_r4_busy_tracks_valid: assert property (@(posedge clk) disable iff (rst)
    busy_o == el_valid_o);

  a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (el_valid_o && el_last_o && !stall_i) |=> !el_valid_o);

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (el_valid_o && stall_i) |=> (el_valid_o && $stable(el_rd_o) && $stable(el_rn_o)
                                 && $stable(el_rm_o) && $stable(el_last_o)
                                 && $stable(el_wb_only_o)));

  a_r9_first_computes: assert property (@(posedge clk) disable iff (rst)
    $rose(el_valid_o) |-> !el_wb_only_o);
endmodule

bind fpv_seq_top fpv_seq_checker #(.IDX_W(IDX_W)) u_fpv_seq_checker (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .stall_i      (stall_i),
  .rd_i         (rd_i),
  .busy_o       (busy_o),
  .el_valid_o   (el_valid_o),
  .el_last_o    (el_last_o),
  .el_wb_only_o (el_wb_only_o),
  .el_rd_o      (el_rd_o),
  .el_rn_o      (el_rn_o),
  .el_rm_o      (el_rm_o)
);

// File: tb/test_fpv_seq_top.sv
`timescale 1ns/1ps
module test_fpv_seq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       dbl_i = 1'b0;
  logic [1:0] op_cls_i = 2'd0;
  logic [4:0] rd_i = '0, rn_i = '0, rm_i = '0;
  logic [2:0] vlen_i = '0;
  logic [1:0] vstride_i = '0;
  logic       stall_i = 1'b0;
  logic       busy_o, el_valid_o, el_last_o, el_wb_only_o;
  logic [4:0] el_rd_o, el_rn_o, el_rm_o;

  always #2 clk = ~clk;

  fpv_seq_top i_fpv_seq_top (
    .clk(clk), .rst(rst), .start_i(start_i), .dbl_i(dbl_i), .op_cls_i(op_cls_i),
    .rd_i(rd_i), .rn_i(rn_i), .rm_i(rm_i), .vlen_i(vlen_i), .vstride_i(vstride_i),
    .stall_i(stall_i), .busy_o(busy_o), .el_valid_o(el_valid_o),
    .el_last_o(el_last_o), .el_wb_only_o(el_wb_only_o),
    .el_rd_o(el_rd_o), .el_rn_o(el_rn_o), .el_rm_o(el_rm_o)
  );

  typedef struct packed {
    logic [4:0] rd, rn, rm;
    logic       last, wb;
  } exp_t;

  exp_t  q[$];
  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  string tag = "R1";

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, cycles=%0d expected below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic int bank_of(int x, bit dbl);
    return dbl ? (x / 4) % 4 : (x / 8) % 4;
  endfunction

  function automatic int step_to(int x, int step, bit dbl);
    int sz = dbl ? 4 : 8;
    return x - (x % sz) + ((x % sz) + step) % sz;
  endfunction

  // Reference expansion of one instruction, from the requirements (R3-R9)
  task automatic expand();
    int  rd = rd_i, rn = rn_i, rm = rm_i;
    int  cls = op_cls_i;
    bit  dbl = dbl_i;
    int  stp = dbl ? (vstride_i / 2) + 1 : vstride_i + 1;
    bit  vec = (cls < 2) && (vlen_i != 0) && (bank_of(rd, dbl) != 0);
    int  n = vec ? vlen_i + 1 : 1;
    bit  bc = vec && (cls == 1) && (bank_of(rm, dbl) == 0);
    for (int e = 0; e < n; e++) begin
      exp_t x;
      x.rd = rd[4:0]; x.rn = rn[4:0]; x.rm = rm[4:0];
      x.last = (e == n - 1);
      x.wb = bc && (e > 0);
      q.push_back(x);
      rd = step_to(rd, stp, dbl);
      if (cls == 0) rn = step_to(rn, stp, dbl);
      if (bank_of(rm, dbl) != 0) rm = step_to(rm, stp, dbl);
    end
  endtask

  task automatic compare();
    exp_t e;
    bit   ev;
    e = '0;
    ev = (q.size() != 0);
    if (ev) e = q[0];
    compared++;
    if (el_valid_o !== ev || busy_o !== ev ||
        (ev && (el_rd_o !== e.rd || el_rn_o !== e.rn || el_rm_o !== e.rm ||
                el_last_o !== e.last || el_wb_only_o !== e.wb)) ||
        (!ev && (el_last_o !== 1'b0 || el_wb_only_o !== 1'b0))) begin
      mismatched++;
      $display("FAIL %s: actual v=%0b b=%0b rd=%0d rn=%0d rm=%0d last=%0b wb=%0b expected v=%0b b=%0b rd=%0d rn=%0d rm=%0d last=%0b wb=%0b",
               tag, el_valid_o, busy_o, el_rd_o, el_rn_o, el_rm_o, el_last_o, el_wb_only_o,
               ev, ev, e.rd, e.rn, e.rm, e.last, e.wb);
    end
  endtask

  task automatic tick(bit st, bit sl);
    @(negedge clk);
    compare();
    start_i = st;
    stall_i = sl;
    if (!rst) begin
      if (q.size() != 0) begin
        if (!sl) void'(q.pop_front());
      end else if (st) begin
        expand();
      end
    end
  endtask

  // mode: 0 plain, 1 stall pattern, 2 start held high while busy
  task automatic run(string t, int cls, bit dbl, int rd, int rn, int rm,
                     int len, int stride, int mode);
    tag = t;
    op_cls_i = cls[1:0]; dbl_i = dbl;
    rd_i = rd[4:0]; rn_i = rn[4:0]; rm_i = rm[4:0];
    vlen_i = len[2:0]; vstride_i = stride[1:0];
    tick(1'b1, 1'b0);
    for (int k = 0; k < 100 && q.size() != 0; k++)
      tick(mode == 2, (mode == 1) && (k % 3 != 0));
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  initial begin
    tag = "R1";
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0);
    rst = 1'b0;
    tick(1'b0, 1'b0);
    run("R3 scalar single",           0, 0,  3, 17, 25, 5, 1, 0);
    run("R3 scalar double",           0, 1,  2, 13,  9, 3, 0, 0);
    run("R2 R4 R7 vector single",     0, 0,  8, 16, 24, 3, 0, 0);
    run("R5 wrap single step2",       0, 0, 13, 30,  9, 4, 1, 0);
    run("R5 wrap single step4",       0, 0, 31, 21, 14, 7, 3, 0);
    run("R5 R6 double mixed stride2", 0, 1,  6, 10,  2, 2, 2, 0);
    run("R5 double stride3",          0, 1, 15,  5, 13, 3, 3, 0);
    run("R5 double stride1",          0, 1,  4,  8, 12, 3, 1, 0);
    run("R6 mixed single",            0, 0, 17, 26,  5, 4, 0, 0);
    run("R8 compare class",           2, 0,  8, 16, 24, 7, 0, 0);
    run("R8 convert class",           3, 1,  5,  9, 13, 2, 1, 0);
    run("R7 single-source vector",    1, 0, 16,  4, 27, 3, 0, 0);
    run("R9 broadcast single",        1, 0, 24,  3,  1, 5, 1, 0);
    run("R9 broadcast double",        1, 1, 14,  7,  3, 2, 0, 0);
    run("R10 stall during vector",    0, 0, 11, 19, 29, 6, 0, 1);
    run("R10 stall broadcast",        1, 0, 20,  0,  6, 3, 2, 1);
    run("R11 start while busy",       0, 0, 10, 18, 26, 4, 1, 2);
    run("R11 start while busy stall", 0, 1,  7, 11, 15, 3, 3, 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule